// File: doc/BRIEF.md
# Configuration Frame LUT Patcher

This block sits in the byte stream that carries configuration data into a programmable fabric. It rewrites the truth table of one chosen 4-input lookup table while the stream goes past. Bytes move through it combinationally under a valid/ready handshake. Internal counters track the byte position inside the current frame and the frame number since the last start pulse. When the counters reach the two bytes that hold the selected LUT, the block puts the encoded truth table in their place. Every other byte leaves the block exactly as it arrived.

The LUT is chosen with five settings:
- the CLB column index;
- the slice column parity inside that CLB column;
- the slice row, counted from the top of the frame;
- a flag that picks the second (F) LUT of the slice instead of the first (G);
- the desired 16-bit truth table.

The frame length is also a setting, because it grows with the number of rows in the fabric. The block sets a done flag once both target bytes have been replaced. It sets an error flag instead if the stream ends before that happens.

Top module: `lut_frame_patcher`

## Requirements
- R1: Every accepted byte whose position is not one of the two target bytes appears on the output unchanged. This includes the 12 leading and 12 trailing I/O bytes of each frame.
- R2: The upper byte (bits 15..8) of the encoded value replaces the byte at offset 12 + 5·row of the target frame. The lower byte replaces the byte that follows it. Row counts from the top, starting at 0.
- R3: When the F LUT is selected, the two replaced bytes sit 3 bytes later than for the G LUT of the same slice, at offsets 15 + 5·row and 16 + 5·row.
- R4: The encoded value for the G LUT is the bitwise inverse of the truth table. For example, truth 0x8000 is written as 0x7FFF.
- R5: The encoded value for the F LUT is the inverse of the truth table with bit order reversed, so that bit i of the result equals NOT truth bit 15−i. For example, truth 0x8000 is written as 0xFFFE.
- R6: The target frame index is 22·column + 1 for even slice parity and 22·column + 2 for odd parity. Frame 0 starts with the first byte accepted after the start pulse.
- R7: A frame is frame_len_i bytes long. After the last byte of a frame, the byte offset returns to 0 and the frame index rises by one.
- R8: A beat is accepted only when both in_valid_i and out_ready_i are high. in_ready_o follows out_ready_i, and out_valid_o follows in_valid_i. While no beat is accepted, the position counters hold, so no byte is skipped or patched twice.
- R9: done_o goes high in the cycle after the lower target byte is accepted, and stays high until the next start pulse.
- R10: If the byte marked last is accepted before the lower target byte has been accepted, err_o goes high and done_o stays low. done_o and err_o are never high together.
- R11: A start_i pulse clears done_o, err_o and both position counters. No beat may be offered in the same cycle as start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-stream pulse |
| frame_len_i | input | FLEN_W | Bytes per frame |
| col_i | input | COL_W | CLB column index of the target |
| odd_i | input | 1 | Slice column parity (1 = odd) |
| row_i | input | ROW_W | Slice row counted from the top |
| sel_f_i | input | 1 | 1 selects the F LUT, 0 the G LUT |
| truth_i | input | 16 | Desired truth table |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted when valid |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Marks the final byte of the stream |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 8 | Output byte, patched or passed through |
| done_o | output | 1 | Both target bytes replaced |
| err_o | output | 1 | Stream ended before the target was reached |

## Verification
The hardest case to reach is a target byte that arrives during backpressure. A miscounted stall would patch a neighbouring byte, or patch the same byte twice, without disturbing the rest of the stream. The stimulus holds out_ready_i low on a random quarter of cycles across streams several thousand bytes long, so many stalls land on or next to the target offsets. The end-of-stream boundary is reached with directed streams that stop just before the upper byte, between the two bytes, and exactly on the lower byte.

// File: rtl/lfp_pkg.sv
package lfp_pkg;
  localparam int unsigned IOB_BYTES      = 12;
  localparam int unsigned SLICE_BYTES    = 5;
  localparam int unsigned F_SKIP         = 3;
  localparam int unsigned FRAMES_PER_COL = 22;
  localparam int unsigned LUT_BITS       = 16;
endpackage

// File: rtl/lfp_lut_encoder.sv
module lfp_lut_encoder
  import lfp_pkg::*;
(
  input  logic [LUT_BITS-1:0] truth_i,
  input  logic                sel_f_i,
  output logic [LUT_BITS-1:0] img_o
);
  logic [LUT_BITS-1:0] inv;
  logic [LUT_BITS-1:0] rev;

  assign inv = ~truth_i;

  for (genvar b = 0; b < LUT_BITS; b++) begin : g_rev
    assign rev[b] = inv[LUT_BITS-1-b];
  end

  assign img_o = sel_f_i ? rev : inv;
endmodule

// File: rtl/lfp_locator.sv
module lfp_locator
  import lfp_pkg::*;
#(
  parameter int unsigned FLEN_W = 10,
  parameter int unsigned FRM_W  = 12,
  parameter int unsigned ROW_W  = 7,
  parameter int unsigned COL_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              beat_i,
  input  logic [FLEN_W-1:0] frame_len_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              odd_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              sel_f_i,
  output logic              hit_hi_o,
  output logic              hit_lo_o
);
  logic [FLEN_W-1:0] byte_cnt;
  logic [FRM_W-1:0]  frame_cnt;
  logic [FLEN_W-1:0] off_hi;
  logic [FLEN_W-1:0] off_lo;
  logic [FRM_W-1:0]  tgt_frame;
  logic              frame_end;
  logic              in_frame;

  assign off_hi    = FLEN_W'(IOB_BYTES + SLICE_BYTES * int'(row_i) + (sel_f_i ? F_SKIP : 0));
  assign off_lo    = off_hi + FLEN_W'(1);
  assign tgt_frame = FRM_W'(FRAMES_PER_COL * int'(col_i) + 1 + int'(odd_i));
  assign frame_end = byte_cnt == frame_len_i - FLEN_W'(1);
  assign in_frame  = frame_cnt == tgt_frame;
  assign hit_hi_o  = in_frame && byte_cnt == off_hi;
  assign hit_lo_o  = in_frame && byte_cnt == off_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_cnt  <= '0;
      frame_cnt <= '0;
    end else if (start_i) begin
      byte_cnt  <= '0;
      frame_cnt <= '0;
    end else if (beat_i) begin
      if (frame_end) begin
        byte_cnt  <= '0;
        frame_cnt <= frame_cnt + FRM_W'(1);
      end else begin
        byte_cnt  <= byte_cnt + FLEN_W'(1);
      end
    end
  end

  p_frame_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && !start_i && frame_end |=>
      byte_cnt == '0 && frame_cnt == FRM_W'($past(frame_cnt) + 1'b1));

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_i && !start_i |=> $stable(byte_cnt) && $stable(frame_cnt));

  p_hit_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_hi_o && hit_lo_o));
endmodule

// File: rtl/lut_frame_patcher.sv
module lut_frame_patcher
  import lfp_pkg::*;
#(
  parameter int unsigned FLEN_W = 10,
  parameter int unsigned FRM_W  = 12,
  parameter int unsigned ROW_W  = 7,
  parameter int unsigned COL_W  = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [FLEN_W-1:0]   frame_len_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic                odd_i,
  input  logic [ROW_W-1:0]    row_i,
  input  logic                sel_f_i,
  input  logic [LUT_BITS-1:0] truth_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [7:0]          in_data_i,
  input  logic                in_last_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [7:0]          out_data_o,
  output logic                done_o,
  output logic                err_o
);
  logic                beat;
  logic                hit_hi;
  logic                hit_lo;
  logic [LUT_BITS-1:0] img;

  assign beat        = in_valid_i && out_ready_i;
  assign in_ready_o  = out_ready_i;
  assign out_valid_o = in_valid_i;

  lfp_lut_encoder u_enc (
    .truth_i (truth_i),
    .sel_f_i (sel_f_i),
    .img_o   (img)
  );

  lfp_locator #(
    .FLEN_W (FLEN_W),
    .FRM_W  (FRM_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W)
  ) u_loc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .beat_i      (beat),
    .frame_len_i (frame_len_i),
    .col_i       (col_i),
    .odd_i       (odd_i),
    .row_i       (row_i),
    .sel_f_i     (sel_f_i),
    .hit_hi_o    (hit_hi),
    .hit_lo_o    (hit_lo)
  );

  always_comb begin
    out_data_o = in_data_i;
    if (hit_hi)      out_data_o = img[15:8];
    else if (hit_lo) out_data_o = img[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else if (start_i) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else if (beat && !done_o && !err_o) begin
      if (hit_lo)         done_o <= 1'b1;
      else if (in_last_i) err_o  <= 1'b1;
    end
  end

  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  p_flags_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  p_start_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o && !err_o);
endmodule

// File: tb/lut_frame_patcher_bench.sv
`timescale 1ns/1ps
module lut_frame_patcher_bench;
  localparam int MAXB = 4096;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [9:0]  frame_len_i = '0;
  logic [5:0]  col_i = '0;
  logic        odd_i = 1'b0;
  logic [6:0]  row_i = '0;
  logic        sel_f_i = 1'b0;
  logic [15:0] truth_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  in_data_i = '0;
  logic        in_last_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [7:0]  out_data_o;
  logic        done_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] src [MAXB];
  logic [7:0] exp_q [MAXB];

  always #2.5 clk_i = ~clk_i;

  lut_frame_patcher u_lut_frame_patcher (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .frame_len_i(frame_len_i),
    .col_i(col_i), .odd_i(odd_i), .row_i(row_i), .sel_f_i(sel_f_i), .truth_i(truth_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .in_last_i(in_last_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_data_o(out_data_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] model_img(input logic [15:0] t, input logic f);
    logic [15:0] v;
    v = ~t;
    if (f) begin
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[15-i];
      v = r;
    end
    return v;
  endfunction

  task automatic run_stream(input int col, input logic odd, input int row, input logic f,
                            input logic [15:0] t, input int flen, input int n);
    int tgt, hi, idx;
    logic [15:0] img;
    string req;
    tgt = 22 * col + 1 + int'(odd);
    hi  = tgt * flen + 12 + 5 * row + (f ? 3 : 0);
    img = model_img(t, f);
    for (int i = 0; i < n; i++) begin
      src[i] = 8'($urandom);
      exp_q[i] = src[i];
    end
    if (hi < n)     exp_q[hi]   = img[15:8];
    if (hi + 1 < n) exp_q[hi+1] = img[7:0];
    @(posedge clk_i); #1;
    col_i = 6'(col); odd_i = odd; row_i = 7'(row); sel_f_i = f; truth_i = t;
    frame_len_i = 10'(flen); start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    chk(!done_o && !err_o, "R11 flags cleared", {done_o, err_o}, 0);
    idx = 0;
    while (idx < n) begin
      in_valid_i = 1'b1;
      in_data_i = src[idx];
      in_last_i = (idx == n - 1);
      out_ready_i = ($urandom % 4) != 0;
      @(negedge clk_i);
      if (out_ready_i) begin
        if (idx == hi)          req = f ? "R2 R3 R5 R6 upper" : "R2 R4 R6 upper";
        else if (idx == hi + 1) req = f ? "R2 R3 R5 R6 lower" : "R2 R4 R6 lower";
        else                    req = "R1 R7 pass";
        chk(out_valid_o && in_ready_o && out_data_o == exp_q[idx], req,
            int'(out_data_o), int'(exp_q[idx]));
        idx++;
      end else begin
        chk(!in_ready_o && out_valid_o, "R8 handshake", int'(in_ready_o), 0);
      end
      @(posedge clk_i); #1;
    end
    in_valid_i = 1'b0; in_last_i = 1'b0; out_ready_i = 1'b1;
    if (hi + 1 < n) begin
      chk(done_o && !err_o, "R9 done", {done_o, err_o}, 2);
    end else begin
      chk(!done_o && err_o, "R10 early end", {done_o, err_o}, 1);
    end
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int flen, tgt, hi, rows, col, row;
    logic odd, f;
    void'($urandom(32'd1234));
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!done_o && !err_o, "R9 R10 reset flags", {done_o, err_o}, 0);
    out_ready_i = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o && !out_valid_o, "R8 idle", {in_ready_o, out_valid_o}, 2);

    flen = 24 + 5 * 4;
    run_stream(0, 1'b0, 0, 1'b0, 16'h8000, flen, 3 * flen);
    run_stream(0, 1'b0, 0, 1'b1, 16'h8000, flen, 3 * flen);
    flen = 24 + 5 * 8;
    run_stream(2, 1'b1, 7, 1'b1, 16'hA5C3, flen, 47 * flen);
    run_stream(1, 1'b0, 7, 1'b0, 16'h1234, flen, 25 * flen);
    tgt = 22 + 1;
    hi = tgt * flen + 12 + 5 * 3;
    run_stream(1, 1'b0, 3, 1'b0, 16'hFFFF, flen, hi);
    run_stream(1, 1'b0, 3, 1'b0, 16'h0F0F, flen, hi + 1);
    run_stream(1, 1'b0, 3, 1'b0, 16'h0001, flen, hi + 2);
    run_stream(1, 1'b0, 3, 1'b1, 16'h0001, flen, hi + 3 + 2);

    for (int k = 0; k < 6; k++) begin
      rows = 2 + int'($urandom % 7);
      flen = 24 + 5 * rows;
      col  = int'($urandom % 3);
      odd  = 1'($urandom);
      row  = int'($urandom % rows);
      f    = 1'($urandom);
      tgt  = 22 * col + 1 + int'(odd);
      run_stream(col, odd, row, f, 16'($urandom), flen, (tgt + 1) * flen + int'($urandom % 20));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule